// File: doc/BRIEF.md
# Programmable Clock Mode Controller

This block is the digital half of a clock generator. It holds one 16-bit mode register on a simple word-addressed bus, picks a reset configuration from three strap pins, and produces the device clock in one of three ways. It can divide the reference clock by 2 or by 4. It can pass the clock of an external PLL through once a programmable lock delay has run out. It can also forward the reference clock unchanged in a strap-only bypass configuration. The analog PLL is outside the block. The block only drives its enable and its ratio code, and it receives the PLL's output clock on `pll_clk_i`.

Software selects multiply mode by setting both the mode bit and the PLL-on bit in one write. Any write reloads the lock timer from the count field. The output stays on the divided clock until that timer reaches zero. The multiplexer then changes its selection only at a reference edge where the divided clock will be low and the synchronised PLL clock is low. The same rule applies to the switch back to the divided clock. A status bit in the register reads back which source is currently driving the output.

Register layout:
- [15:12] multiplier code
- [11] half-step qualifier
- [10:3] lock count
- [2] PLL on
- [1] multiply select
- [0] status

Top module: `clkmode_ctrl`

## Requirements
- R1: Under reset (synchronous, active high), the register loads a value chosen by the straps {strap_i[2],strap_i[1],strap_i[0]}: 000→E007h, 001→9007h, 010→4007h, 100→1007h, 110→F007h, 111→0000h, 101→F000h. A read after reset returns exactly that value, with bit 0 set when multiply mode is engaged.
- R2: Strap 011 is bypass. The register reads 0000h, `pll_en_o` is 0 and `clk_out_o` follows `clk`. The first register write ends bypass.
- R3: A write hits only when `bus_sel_i` and `bus_we_i` are 1 and `bus_addr_i` equals REG_ADDR (default 0058h). A read returns data on `bus_rdata_o` one cycle after the request. A read of any other address returns 0, and a write to any other address leaves the register unchanged.
- R4: Writes to bit 0 have no effect. Bit 0 reads 1 exactly when the PLL clock drives the output.
- R5: With bit 1 or bit 2 clear, the output is the divided reference clock. It divides by 4 when bits [15:12] are 1111b and by 2 otherwise.
- R6: `pll_en_o` is 1 only when bits 1 and 2 are both set and the block is not in bypass.
- R7: `pll_ratio_o` gives the ratio in quarter units, from code M = bits [15:12] and qualifier Q = bit 11. Q=0, M<15 gives 4(M+1). Q=0, M=15 gives 4. Q=1, M<15 gives 2(2M+1). Q=1, M=15 gives 1. These 31 ratios are distinct.
- R8: After a write that engages multiply mode with lock count N, the output moves to the PLL clock no earlier than 16·N reference cycles later. With N=0 the switch follows within a few cycles.
- R9: A write while the lock timer runs restarts the timer from the newly written count.
- R10: A write that selects divide mode returns the output to the divided clock and clears status within a few reference cycles. Every change of source happens at an edge where the next divided level is low and the synchronised PLL clock is low.
- R11: While status is 1, `clk_out_o` equals `pll_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 3 | Reset configuration straps |
| bus_sel_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| pll_clk_i | input | 1 | Output clock of the external PLL |
| pll_en_o | output | 1 | PLL power enable |
| pll_ratio_o | output | 6 | Multiplication ratio in quarter units |
| pll_active_o | output | 1 | PLL clock currently selected |
| clk_out_o | output | 1 | Device clock |

## Verification
The bench uses the default parameters: a 16-bit address with the register at 0058h, a 16-cycle lock prescaler, a 2-bit divider counter and a two-stage synchroniser. With these values a lock count of 3 or 4 gives a 48 or 64 cycle hold-off, short enough to observe both sides of the switch and a timer restart in a few hundred cycles. The PLL model runs with a period of 8 against a reference period of 10. Its low phases therefore drift across the reference edges, which exercises the gating of the source switch. Every strap code, including bypass, is reached through its own reset.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int REG_W     = 16;
  localparam int MULT_HI   = 15;
  localparam int MULT_LO   = 12;
  localparam int QUAL_BIT  = 11;
  localparam int LOCK_HI   = 10;
  localparam int LOCK_LO   = 3;
  localparam int PLLON_BIT = 2;
  localparam int MODE_BIT  = 1;
  localparam int LOCK_W    = LOCK_HI - LOCK_LO + 1;
  localparam int RATIO_W   = 6;
  localparam logic [2:0] STRAP_BYPASS = 3'b011;

  function automatic logic [REG_W-1:0] strap_value(input logic [2:0] s);
    logic [REG_W-1:0] v;
    case (s)
      3'b000:  v = 16'hE007;
      3'b001:  v = 16'h9007;
      3'b010:  v = 16'h4007;
      3'b100:  v = 16'h1007;
      3'b110:  v = 16'hF007;
      3'b101:  v = 16'hF000;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_quarters(input logic [3:0] m, input logic q);
    logic [RATIO_W-1:0] r;
    if (m == 4'hF) r = q ? RATIO_W'(1) : RATIO_W'(4);
    else if (q)    r = RATIO_W'({m, 1'b0} + 5'd1) << 1;
    else           r = RATIO_W'(m + 5'd1) << 2;
    return r;
  endfunction
endpackage

// File: rtl/clkmode_regs.sv
module clkmode_regs
  import clkmode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h58
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        strap_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  input  logic              status_i,
  output logic [3:0]        mult_o,
  output logic              qual_o,
  output logic              pll_on_o,
  output logic              mult_mode_o,
  output logic              wr_hit_o,
  output logic              bypass_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:1] reg_q;
  logic             bypass_q;
  logic [REG_W-1:0] rdata_q;
  logic             hit, rd_hit;
  logic             unused_wbit0;

  assign unused_wbit0 = bus_wdata_i[0];
  assign hit      = bus_sel_i && (bus_addr_i == REG_ADDR);
  assign wr_hit_o = hit && bus_we_i;
  assign rd_hit   = hit && !bus_we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= strap_value(strap_i)[REG_W-1:1];
      bypass_q <= (strap_i == STRAP_BYPASS);
      rdata_q  <= '0;
    end else begin
      if (wr_hit_o) begin
        reg_q    <= bus_wdata_i[REG_W-1:1];
        bypass_q <= 1'b0;
      end
      rdata_q <= rd_hit ? {reg_q, status_i} : '0;
    end
  end

  assign mult_o      = reg_q[MULT_HI:MULT_LO];
  assign qual_o      = reg_q[QUAL_BIT];
  assign pll_on_o    = reg_q[PLLON_BIT];
  assign mult_mode_o = reg_q[MODE_BIT];
  assign bypass_o    = bypass_q;
  assign rdata_o     = rdata_q;

  // R3: foreign addresses read back as zero
  assert_foreign_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel_i && !bus_we_i && bus_addr_i != REG_ADDR) |=> (rdata_o == '0));
endmodule

// File: rtl/clkmode_lock_timer.sv
module clkmode_lock_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      pre_q <= '0;
    end else if (cnt_q != '0) begin
      pre_q <= pre_q + 1'b1;
      if (&pre_q) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

  // R8: a running count only holds or steps down by one
  assert_timer_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i) && $past(cnt_q) != '0) |->
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  // R9: every write restarts the count from the written value
  assert_timer_reload_R9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/clkmode_divider.sv
module clkmode_divider #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic div4_i,
  output logic div_clk_o,
  output logic low_next_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             div_q;
  logic             div_bit;

  assign cnt_next = cnt_q + 1'b1;
  assign div_bit  = div4_i ? cnt_next[1] : cnt_next[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      div_q <= div_bit;
    end
  end

  assign div_clk_o  = div_q;
  assign low_next_o = !div_bit;

  // R5: in divide-by-2 the divided clock changes level every reference cycle
  assert_div2_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !div4_i && !$past(div4_i)) |-> (div_clk_o != $past(div_clk_o)));
endmodule

// File: rtl/clkmode_switch.sv
module clkmode_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_sel_i,
  input  logic pll_clk_i,
  input  logic req_pll_i,
  input  logic div_low_next_i,
  output logic sel_pll_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sel_q;
  logic                   pll_low;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[i] <= 1'b0;
      else     sync_q[i] <= (i == 0) ? pll_clk_i : sync_q[(i == 0) ? 0 : i-1];
    end
  end

  assign pll_low = !sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= rst_sel_i;
    else if ((req_pll_i != sel_q) && div_low_next_i && pll_low)
      sel_q <= req_pll_i;
  end

  assign sel_pll_o = sel_q;

  // R10: the source changes only when both clocks are low
  assert_switch_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sel_q != $past(sel_q)) |-> ($past(div_low_next_i) && $past(pll_low)));
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h58,
  parameter int PRE_W = 4,
  parameter int DIV_CNT_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        strap_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  input  logic              pll_clk_i,
  output logic              pll_en_o,
  output logic [5:0]        pll_ratio_o,
  output logic              pll_active_o,
  output logic              clk_out_o
);
  logic [3:0] mult;
  logic       qual, pll_on, mult_mode, wr_hit, bypass;
  logic       lock_done, req_pll, sel_pll;
  logic       div_clk, div_low_next;
  logic       rst_sel;
  logic [REG_W-1:0] strap_v;

  assign strap_v = strap_value(strap_i);
  assign rst_sel = strap_v[PLLON_BIT] && strap_v[MODE_BIT];

  clkmode_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .strap_i(strap_i),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .status_i(sel_pll),
    .mult_o(mult), .qual_o(qual), .pll_on_o(pll_on), .mult_mode_o(mult_mode),
    .wr_hit_o(wr_hit), .bypass_o(bypass), .rdata_o(bus_rdata_o)
  );

  clkmode_lock_timer #(.CNT_W(LOCK_W), .PRE_W(PRE_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(wr_hit),
    .load_val_i(bus_wdata_i[LOCK_HI:LOCK_LO]), .done_o(lock_done)
  );

  clkmode_divider #(.CNT_W(DIV_CNT_W)) u_div (
    .clk(clk), .rst(rst), .div4_i(mult == 4'hF),
    .div_clk_o(div_clk), .low_next_o(div_low_next)
  );

  assign pll_en_o = pll_on && mult_mode && !bypass;
  assign req_pll  = pll_en_o && lock_done;

  clkmode_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
    .clk(clk), .rst(rst), .rst_sel_i(rst_sel), .pll_clk_i(pll_clk_i),
    .req_pll_i(req_pll), .div_low_next_i(div_low_next), .sel_pll_o(sel_pll)
  );

  assign pll_ratio_o  = ratio_quarters(mult, qual);
  assign pll_active_o = sel_pll;
  assign clk_out_o    = bypass ? clk : (sel_pll ? pll_clk_i : div_clk);

  // R11: the PLL clock is selected only after the PLL has been enabled
  assert_active_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(sel_pll)) |-> $past(pll_en_o));
endmodule

// File: tb/clkmode_ctrl_bench.sv
module clkmode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 0, rst = 1, pll_clk = 0;
  logic [2:0]  strap = 3'b111;
  logic        bus_sel = 0, bus_we = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        pll_en, pll_active, clk_out;
  logic [5:0]  pll_ratio;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #4 pll_clk = ~pll_clk;

  clkmode_ctrl u_clkmode_ctrl (
    .clk(clk), .rst(rst), .strap_i(strap), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pll_clk_i(pll_clk), .pll_en_o(pll_en), .pll_ratio_o(pll_ratio),
    .pll_active_o(pll_active), .clk_out_o(clk_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_strap(input logic [2:0] s);
    case (s)
      3'b000: return 16'hE007;
      3'b001: return 16'h9007;
      3'b010: return 16'h4007;
      3'b100: return 16'h1007;
      3'b110: return 16'hF007;
      3'b101: return 16'hF000;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk); strap = s; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_trans(output int n);
    logic prev;
    n = 0;
    @(negedge clk); #1 prev = clk_out;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); #1;
      if (clk_out != prev) n++;
      prev = clk_out;
    end
  endtask

  task automatic t_straps;
    logic [15:0] d;
    for (int s = 0; s < 8; s++) begin
      if (s == 3) continue;
      do_reset(3'(s));
      rd(16'h0058, d);
      chk($sformatf("R1 strap %0d", s), d, exp_strap(3'(s)));
    end
  endtask

  task automatic t_bypass;
    logic [15:0] d;
    int n;
    do_reset(3'b011);
    rd(16'h0058, d);
    chk("R2 bypass reg", d, 16'h0000);
    chk("R2 bypass pll_en", pll_en, 0);
    @(negedge clk); #1 chk("R2 bypass low", clk_out, 0);
    @(posedge clk); #1 chk("R2 bypass high", clk_out, 1);
    wr(16'h0058, 16'h0000);
    wait_cyc(4);
    count_trans(n);
    chk("R2 bypass ends on write", n, 7);
  endtask

  task automatic t_bus;
    logic [15:0] d;
    do_reset(3'b111);
    wr(16'h0059, 16'h1234);
    rd(16'h0058, d);
    chk("R3 foreign write ignored", d, 16'h0000);
    rd(16'h0059, d);
    chk("R3 foreign read zero", d, 16'h0000);
    wr(16'h0058, 16'hF001);
    rd(16'h0058, d);
    chk("R4 bit0 write ignored", d, 16'hF000);
  endtask

  task automatic t_divide;
    logic [15:0] d;
    int n;
    do_reset(3'b111);
    wait_cyc(2);
    count_trans(n);
    chk("R5 divide by 2", n, 7);
    wr(16'h0058, 16'hF000);
    wait_cyc(4);
    count_trans(n);
    chk("R5 divide by 4", (n == 3 || n == 4), 1);
    chk("R6 pll_en off in divide", pll_en, 0);
    wr(16'h0058, 16'hF004);
    chk("R6 pll_en off, mode bit clear", pll_en, 0);
    wr(16'h0058, 16'h0002);
    chk("R6 pll_en off, pll bit clear", pll_en, 0);
    wait_cyc(12);
    rd(16'h0058, d);
    chk("R5 stays divided without pll on", d, 16'h0002);
  endtask

  task automatic t_ratio;
    do_reset(3'b000);
    chk("R7 x15 reset ratio", pll_ratio, 60);
    wr(16'h0058, 16'h3806); chk("R7 x3.5", pll_ratio, 14);
    wr(16'h0058, 16'hF806); chk("R7 x0.25", pll_ratio, 1);
    wr(16'h0058, 16'hF006); chk("R7 x1", pll_ratio, 4);
    wr(16'h0058, 16'h9006); chk("R7 x10", pll_ratio, 40);
  endtask

  task automatic t_lock;
    logic [15:0] d;
    do_reset(3'b111);
    wr(16'h0058, 16'h001E);
    chk("R6 pll_en on in multiply", pll_en, 1);
    wait_cyc(38);
    rd(16'h0058, d);
    chk("R8 held before lock", d[0], 0);
    wait_cyc(30);
    rd(16'h0058, d);
    chk("R8 switched after lock", d, 16'h001F);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1 chk("R11 output follows pll", clk_out, pll_clk);
    end
    wr(16'h0058, 16'h0000);
    wait_cyc(12);
    rd(16'h0058, d);
    chk("R10 status cleared", d, 16'h0000);
    chk("R10 pll_en off", pll_en, 0);
    wr(16'h0058, 16'h0006);
    wait_cyc(12);
    rd(16'h0058, d);
    chk("R8 zero count immediate", d, 16'h0007);
  endtask

  task automatic t_restart;
    logic [15:0] d;
    int n;
    do_reset(3'b111);
    wr(16'h0058, 16'h0026);
    wait_cyc(40);
    wr(16'h0058, 16'h0026);
    wait_cyc(40);
    rd(16'h0058, d);
    chk("R9 restart delays switch", d[0], 0);
    wait_cyc(40);
    rd(16'h0058, d);
    chk("R9 switch after restarted count", d[0], 1);
    wr(16'h0058, 16'h0000);
    wait_cyc(12);
    count_trans(n);
    chk("R10 back to divide by 2", n, 7);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_straps();
    t_bypass();
    t_bus();
    t_divide();
    t_ratio();
    t_lock();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule